// File: doc/BRIEF.md
# Trigger-Gated Sample Clock Generator

This block produces a strobe for a parallel pattern-capture port. The strobe starts on one edge of a trigger line and stops on the next edge of the same line. The trigger is synchronized and edge-detected. Each rising edge then decrements a gate counter of width `GATE_W`, and arming loads that counter with one. Its gate output toggles twice. It goes high when the count reaches zero, and it goes low when the count wraps from zero to all ones. While the gate is high, a period counter makes a pulse train with a programmable period and high time, and that pulse train is the sample clock.

A host stages the period and high-time settings, then pulses `arm`. After that, external trigger pulses start and stop capture. A stop request ends generation early. After a stop, the block stays done and ignores the trigger until it is armed again.

Top module: `trig_gated_sclk`

## Requirements
- R1: After synchronous reset, `sclk`, `running` and `done` are all 0.
- R2: After `arm`, the first rising edge of `trig` sets `running` on the third rising clock edge that sees `trig` high. On the two earlier edges, `running` stays 0. The gate counter goes from 1 to 0.
- R3: The second rising trigger edge clears `running` and sets `done` with the same 3-edge latency, and the gate counter wraps to all ones. Until then, `sclk` keeps its pattern.
- R4: `sclk` is 0 in every cycle in which `running` is 0.
- R5: Number the cycles from the first cycle with `running` high as j = 0. With effective period P and effective high time H, `sclk` is 1 exactly when (j mod P) >= P - H. So the first high comes P - H cycles after the start.
- R6: When `running` falls inside a high phase, `sclk` drops in that same cycle.
- R7: `stop_req` ends generation on the next clock edge: `running` goes to 0 and `done` goes to 1.
- R8: Trigger edges before any arm, and trigger edges after `done`, have no effect. `arm` clears `done` and reloads the count to 1.
- R9: `period_cfg` and `high_cfg` are latched only while `running` is 0. Changing them during a run does not alter `sclk`.
- R10: A period below 2 is used as 2. A high time of 0 is used as 1, and a high time of P or more is used as P - 1.
- R11: Only rising edges of `trig` count. Holding `trig` high does not stop the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Arm pulse: reload gate count to 1, clear done |
| trig | input | 1 | Asynchronous start/stop trigger |
| stop_req | input | 1 | Software stop request |
| period_cfg | input | PER_W | Sample clock period in system clocks |
| high_cfg | input | PER_W | Sample clock high time in system clocks |
| sclk | output | 1 | Gated sample clock |
| running | output | 1 | Gate is open |
| done | output | 1 | Run ended by trigger or stop |

## Verification
The hardest cases to reach from the ports are the moments when the gate closes. One is a gate that closes while the sample clock is in a high phase. Another is a trigger held high across the whole run, where a level must not count as an edge. A third is a configuration change made mid-run, which must stay invisible. Directed runs set the run length against the period so that the second trigger lands in a high phase. Other directed runs hold the trigger high until just before the stop edge. Every run rewrites the period and high settings one cycle after the start. Random runs vary the period, the high time, the run length and the way each run ends.

// File: rtl/trig_gated_sclk.sv
module trig_gated_sclk #(
  parameter int GATE_W = 24,
  parameter int PER_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             trig,
  input  logic             stop_req,
  input  logic [PER_W-1:0] period_cfg,
  input  logic [PER_W-1:0] high_cfg,
  output logic             sclk,
  output logic             running,
  output logic             done
);
  localparam logic [GATE_W-1:0] GATE_ONE  = GATE_W'(1);
  localparam logic [GATE_W-1:0] GATE_WRAP = '1;
  localparam logic [PER_W-1:0]  PER_MIN   = PER_W'(2);

  logic             t1, t2, t3, trig_rise;
  logic             armed, gate, done_q;
  logic [GATE_W-1:0] gcnt;
  logic [PER_W-1:0] per_q, hi_q, pcnt;
  logic [PER_W-1:0] per_eff, hi_eff, lo_q;

  always_ff @(posedge clk) begin
    if (rst) {t1, t2, t3} <= '0;
    else     {t1, t2, t3} <= {trig, t1, t2};
  end
  assign trig_rise = t2 & ~t3;

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt <= '0; gate <= 1'b0; armed <= 1'b0; done_q <= 1'b0;
    end else if (arm) begin
      gcnt <= GATE_ONE; gate <= 1'b0; armed <= 1'b1; done_q <= 1'b0;
    end else if (stop_req && armed) begin
      gate <= 1'b0; armed <= 1'b0; done_q <= 1'b1;
    end else if (trig_rise && armed) begin
      gcnt <= gcnt - GATE_ONE;
      if (gcnt == GATE_ONE) gate <= 1'b1;
      if (gcnt == '0) begin
        gate <= 1'b0; armed <= 1'b0; done_q <= 1'b1;
      end
    end
  end

  assign per_eff = (period_cfg < PER_MIN) ? PER_MIN : period_cfg;
  assign hi_eff  = (high_cfg == '0) ? PER_W'(1) :
                   (high_cfg >= per_eff) ? per_eff - PER_W'(1) : high_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= PER_MIN; hi_q <= PER_W'(1);
    end else if (!gate) begin
      per_q <= per_eff; hi_q <= hi_eff;
    end
  end
  assign lo_q = per_q - hi_q;

  always_ff @(posedge clk) begin
    if (rst || !gate)                pcnt <= '0;
    else if (pcnt == per_q - PER_W'(1)) pcnt <= '0;
    else                             pcnt <= pcnt + PER_W'(1);
  end

  assign sclk    = gate & (pcnt >= lo_q);
  assign running = gate;
  assign done    = done_q;

  p_reset_r1: assert property (@(posedge clk) rst |=> !running && !done);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> gcnt == '0 && $past(gcnt) == GATE_ONE);
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(running) && !$past(stop_req) && !$past(arm) |-> gcnt == GATE_WRAP && done);
  p_quiet_r4: assert property (@(posedge clk) disable iff (rst) done |-> !sclk && !running);
  p_first_low_r5: assert property (@(posedge clk) disable iff (rst) $rose(running) |-> !sclk);
  p_stop_r7: assert property (@(posedge clk) disable iff (rst)
    stop_req && !arm && (running || armed) |=> !running && done);
  p_arm_r8: assert property (@(posedge clk) disable iff (rst)
    $past(arm && !rst) |-> gcnt == GATE_ONE && !done && !running);
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    running && $past(running) |-> $stable(per_q) && $stable(hi_q));
  p_clamp_r10: assert property (@(posedge clk) disable iff (rst)
    per_q >= PER_MIN && hi_q != '0 && hi_q < per_q);
endmodule

// File: tb/sim_trig_gated_sclk.sv
module sim_trig_gated_sclk;
  localparam int PW = 16;
  logic clk = 0, rst = 1, arm = 0, trig = 0, stop_req = 0;
  logic [PW-1:0] period_cfg = 4, high_cfg = 2;
  logic sclk, running, done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  trig_gated_sclk #(.GATE_W(24), .PER_W(PW)) u0 (
    .clk(clk), .rst(rst), .arm(arm), .trig(trig), .stop_req(stop_req),
    .period_cfg(period_cfg), .high_cfg(high_cfg),
    .sclk(sclk), .running(running), .done(done));

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int e_per(int p); return (p < 2) ? 2 : p; endfunction
  function automatic int e_hi(int p, int h);
    int ep = e_per(p);
    if (h == 0) return 1;
    if (h >= ep) return ep - 1;
    return h;
  endfunction
  function automatic bit e_sclk(int p, int h, int j);
    int ep = e_per(p);
    return (j % ep) >= (ep - e_hi(p, h));
  endfunction

  task automatic run(int p, int h, int len, bit use_stop, bit hold);
    int bad = 0;
    @(negedge clk); period_cfg = PW'(p); high_cfg = PW'(h); arm = 1;
    @(negedge clk); arm = 0;
    chk(done == 0 && running == 0, "R8 arm clears done", done, 0);
    trig = 1;
    @(negedge clk); @(negedge clk);
    chk(running == 0, "R2 not before sync", running, 0);
    @(negedge clk);
    chk(running == 1, "R2 start", running, 1);
    for (int j = 0; j < len; j++) begin
      if (j > 0) @(negedge clk);
      if (sclk !== e_sclk(p, h, j) || running !== 1) bad++;
      if (j == 1) begin
        period_cfg = PW'($urandom_range(0, 20));
        high_cfg   = PW'($urandom_range(0, 20));
      end
      if (j == (hold ? len - 3 : 1)) trig = 0;
    end
    chk(bad == 0, "R5 R9 R10 pattern", bad, 0);
    if (hold) chk(running == 1, "R11 level ignored", running, 1);
    if (use_stop) begin
      stop_req = 1;
      @(negedge clk); stop_req = 0;
      chk(running == 0 && sclk == 0, "R7 stop", running, 0);
      chk(done == 1, "R7 done", done, 1);
    end else begin
      trig = 1;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(running == 1 && sclk == e_sclk(p, h, len + k), "R3 runs during sync",
            sclk, e_sclk(p, h, len + k));
      end
      @(negedge clk);
      chk(running == 0 && done == 1, "R3 stop", running, 0);
      chk(sclk == 0, "R6 drop at once", sclk, 0);
      trig = 0;
    end
    @(negedge clk); trig = 1;
    repeat (2) @(negedge clk);
    trig = 0;
    repeat (4) @(negedge clk);
    chk(running == 0 && done == 1, "R8 ignored after done", running, 0);
    chk(sclk == 0, "R4 quiet when stopped", sclk, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    chk(sclk == 0 && running == 0 && done == 0, "R1 reset", running, 0);
    trig = 1; repeat (3) @(negedge clk); trig = 0; repeat (3) @(negedge clk);
    chk(running == 0 && sclk == 0, "R8 unarmed ignored", running, 0);
    run(4, 2, 12, 0, 0);
    run(6, 3, 8, 0, 0);
    run(0, 0, 9, 0, 0);
    run(5, 9, 11, 1, 0);
    run(7, 2, 15, 0, 1);
    run(3, 1, 10, 1, 1);
    for (int i = 0; i < 10; i++)
      run($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(5, 40),
          $urandom_range(0, 1), $urandom_range(0, 1));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule